// File: doc/BRIEF.md
# Single-Frame Mailbox Network Interface

This block connects a processor bus to a byte-stream network port and moves one frame at a time in each direction. A small register window identifies the block and exposes a busy flag, the receive and transmit byte counts, an interrupt control register and two byte-wide data ports. An incoming frame is written into a receive buffer, and the processor then pops it one byte per read. The processor fills a transmit buffer one byte per write. The frame leaves on the output stream once the programmed count is reached.

The busy flag gates reception. While it is set, the receive stream is held off by backpressure. The processor clears busy by acknowledging interrupt flags through the interrupt control register. Writing the test bit of that register performs a soft reset and leaves the test flag raised. A single level interrupt output is high while any flag is set. Each buffer is a single-port synchronous RAM, and bus accesses complete through a request/acknowledge handshake.

Top module: `pmb_mailbox_nic`

## Requirements
- R1: Offset 0x00 reads ID_WORD0 (default 0x4D495053) and offset 0x04 reads ID_WORD1 (default 0x4E455430). Offset 0x18, the transmit data port (0x20) and every unmapped offset read 0.
- R2: irq_o is high exactly while at least one interrupt flag is set. The flags are bit 0 (transmit done), bit 1 (receive done) and bit 31 (test) of the interrupt control register at offset 0x14.
- R3: A read of offset 0x14 returns the current flags and then clears the test flag.
- R4: A write to 0x14 is decoded with priority. Bit 0 set clears transmit done only. Otherwise, bit 1 set clears receive done only. Otherwise, bit 31 set performs a soft reset and then sets the test flag. A write of 0 changes no flag.
- R5: After any write to 0x14, busy (bit 0 of offset 0x08) is 1 if any flag remains set and 0 otherwise.
- R6: While busy is 1 and no frame is in progress, rx_ready_o is low and no frame is taken.
- R7: A frame of MAX_FRAME (1514) bytes or more is consumed and discarded. The receive count, busy and flags are unchanged.
- R8: An accepted frame of length L < 1514 sets busy and receive done and loads the receive count (offset 0x0C) with L. Reads of offset 0x1C then return its bytes in arrival order, and each read decrements the count.
- R9: A read of 0x1C while the receive count is 0 returns 0 and changes nothing.
- R10: A write to the transmit count (offset 0x10) loads the value if it is at most 1514 and loads 0 otherwise. Either write restarts the transmit fill pointer.
- R11: Each write to 0x20 stores bits 7:0. When the number of stored bytes equals the transmit count, or reaches 1514, that many bytes are sent. The count is cleared, transmit done is set and busy is set.
- R12: A sent frame appears on tx_data_o in write order, one byte per tx_valid_o/tx_ready_i handshake, with tx_last_o on the final byte. Output is held while tx_ready_i is low. Writes to 0x20 receive no acknowledge until the frame has left.
- R13: After rst_ni, and after a soft reset, busy is 1 and the counts and flags are 0, apart from the test flag set by a soft reset. Writes to read-only offsets are ignored.
- R14: An access that is not stalled is acknowledged with bus_ack_o one cycle after it is taken. bus_ack_o never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset within the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_ack_o |
| bus_ack_o | output | 1 | Access complete |
| irq_o | output | 1 | Level interrupt |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Final byte of the receive frame |
| rx_ready_o | output | 1 | Receive byte taken |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of the transmit frame |
| tx_ready_i | input | 1 | Transmit byte taken by the sink |

## Verification
The closing byte of a one-byte receive frame and the transmit data write that completes a frame are both launched in the same clock cycle. The receive commit and the transmit trigger therefore update the flags, the busy bit and the counts together. The check requires that the interrupt control register then reads both done flags, that busy is 1, that the receive count is 1 and that the written byte leaves on the output stream. A second overlap holds the output sink stalled while the processor writes the next transmit byte. The check judges that this write is acknowledged only after the earlier frame has drained, and that both frames arrive in order.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam logic [5:0] OFF_ID0     = 6'h00;
  localparam logic [5:0] OFF_ID1     = 6'h04;
  localparam logic [5:0] OFF_BUSY    = 6'h08;
  localparam logic [5:0] OFF_RXCNT   = 6'h0C;
  localparam logic [5:0] OFF_TXCNT   = 6'h10;
  localparam logic [5:0] OFF_IRQCTL  = 6'h14;
  localparam logic [5:0] OFF_IRQINFO = 6'h18;
  localparam logic [5:0] OFF_RXDAT   = 6'h1C;
  localparam logic [5:0] OFF_TXDAT   = 6'h20;

  localparam int unsigned FLAG_TX   = 0;
  localparam int unsigned FLAG_RX   = 1;
  localparam int unsigned FLAG_TEST = 31;

  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_SHOW} tx_state_e;
endpackage

// File: rtl/pmb_spram.sv
module pmb_spram #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // read data holds between enabled reads
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/pmb_rx_ingest.sv
module pmb_rx_ingest #(
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned CW        = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  input  logic          gate_ok_i,
  input  logic          hold_i,
  input  logic          abort_i,
  output logic          in_frame_o,
  output logic          ram_we_o,
  output logic [CW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic          commit_o,
  output logic [CW-1:0] commit_len_o
);
  logic          in_frame_q, drop_q;
  logic [CW-1:0] idx_q;
  logic          fire, too_long, drop_now;
  logic [CW-1:0] pos;

  assign rx_ready_o   = !hold_i && (in_frame_q || gate_ok_i);
  assign fire         = rx_valid_i && rx_ready_o;
  assign pos          = in_frame_q ? idx_q : '0;
  assign too_long     = pos >= CW'(MAX_FRAME - 1);
  assign drop_now     = (in_frame_q && drop_q) || too_long || abort_i;
  assign ram_we_o     = fire && !drop_now;
  assign ram_addr_o   = pos;
  assign ram_wdata_o  = rx_data_i;
  assign commit_o     = fire && rx_last_i && !drop_now;
  assign commit_len_o = pos + 1'b1;
  assign in_frame_o   = in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      idx_q      <= '0;
    end else if (fire) begin
      if (rx_last_i) begin
        in_frame_q <= 1'b0;
        drop_q     <= 1'b0;
        idx_q      <= '0;
      end else begin
        in_frame_q <= 1'b1;
        drop_q     <= drop_now;
        idx_q      <= too_long ? pos : pos + 1'b1;  // saturate while discarding
      end
    end else if (abort_i && in_frame_q) begin
      drop_q <= 1'b1;
    end
  end

  p_commit_short_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_len_o < CW'(MAX_FRAME));
  p_idx_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_q |-> idx_q <= CW'(MAX_FRAME - 1));
endmodule

// File: rtl/pmb_tx_stream.sv
module pmb_tx_stream
  import pmb_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          ram_re_o,
  output logic [CW-1:0] ram_addr_o,
  input  logic [7:0]    ram_q_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i
);
  tx_state_e     state_q;
  logic [CW-1:0] idx_q, len_q;

  assign busy_o     = state_q != TX_IDLE;
  assign ram_re_o   = state_q == TX_FETCH;
  assign ram_addr_o = idx_q;
  assign tx_valid_o = state_q == TX_SHOW;
  assign tx_data_o  = ram_q_i;
  assign tx_last_o  = tx_valid_o && (idx_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          len_q   <= len_i;
          idx_q   <= '0;
          state_q <= TX_FETCH;
        end
        TX_FETCH: state_q <= TX_SHOW;
        TX_SHOW: if (tx_ready_i) begin
          if (tx_last_o) state_q <= TX_IDLE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= TX_FETCH;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  p_no_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == TX_IDLE);
endmodule

// File: rtl/pmb_mailbox_nic.sv
module pmb_mailbox_nic
  import pmb_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned BUF_DEPTH = 2048,
  parameter logic [31:0] ID_WORD0  = 32'h4D49_5053,
  parameter logic [31:0] ID_WORD1  = 32'h4E45_5430
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        bus_ack_o,
  output logic        irq_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  localparam int unsigned CW = $clog2(BUF_DEPTH);

  logic          busy_q, flag_tx_q, flag_rx_q, flag_test_q;
  logic [CW-1:0] rx_cnt_q, rx_rd_q, tx_cnt_q, tx_wr_q;
  logic          ack_q, pend_q;
  logic [31:0]   rdata_q, rd_word;

  logic          n_busy, n_ftx, n_frx, n_ftest;
  logic [CW-1:0] n_rx_cnt, n_rx_rd, n_tx_cnt, n_tx_wr, tx_next;
  logic          tx_busy, tx_fire, serve, rd, wr;
  logic          rd_ic, wr_ic, wr_txcnt, wr_txdat, rx_pop, soft_rst;

  logic          rx_we, rx_commit, rx_in_frame, gate_ok;
  logic [CW-1:0] rx_waddr, rx_len;
  logic [7:0]    rx_wdata, rx_ram_q;
  logic          st_re;
  logic [CW-1:0] st_addr;
  logic [7:0]    tx_ram_q;

  // bus front end: one access taken per ack, TX data writes stall while a frame leaves
  assign serve    = bus_req_i && !ack_q && !(bus_we_i && bus_addr_i == OFF_TXDAT && tx_busy);
  assign rd       = serve && !bus_we_i;
  assign wr       = serve && bus_we_i;
  assign rd_ic    = rd && bus_addr_i == OFF_IRQCTL;
  assign wr_ic    = wr && bus_addr_i == OFF_IRQCTL;
  assign wr_txcnt = wr && bus_addr_i == OFF_TXCNT;
  assign wr_txdat = wr && bus_addr_i == OFF_TXDAT;
  assign rx_pop   = rd && bus_addr_i == OFF_RXDAT && rx_cnt_q != '0;
  assign soft_rst = wr_ic && !bus_wdata_i[FLAG_TX] && !bus_wdata_i[FLAG_RX] && bus_wdata_i[FLAG_TEST];
  assign tx_next  = tx_wr_q + 1'b1;
  assign gate_ok  = !busy_q && (rx_cnt_q < CW'(MAX_FRAME));

  assign irq_o       = flag_tx_q || flag_rx_q || flag_test_q;
  assign bus_ack_o   = ack_q;
  assign bus_rdata_o = pend_q ? {24'b0, rx_ram_q} : rdata_q;

  always_comb begin
    rd_word = '0;
    case (bus_addr_i)
      OFF_ID0:    rd_word = ID_WORD0;
      OFF_ID1:    rd_word = ID_WORD1;
      OFF_BUSY:   rd_word = {31'b0, busy_q};
      OFF_RXCNT:  rd_word = 32'(rx_cnt_q);
      OFF_TXCNT:  rd_word = 32'(tx_cnt_q);
      OFF_IRQCTL: rd_word = {flag_test_q, 29'b0, flag_rx_q, flag_tx_q};
      default:    rd_word = '0;
    endcase
  end

  always_comb begin
    n_busy   = busy_q;
    n_rx_cnt = rx_cnt_q;
    n_rx_rd  = rx_rd_q;
    n_tx_cnt = tx_cnt_q;
    n_tx_wr  = tx_wr_q;
    n_ftx    = flag_tx_q;
    n_frx    = flag_rx_q;
    n_ftest  = flag_test_q;
    tx_fire  = 1'b0;
    if (rd_ic) n_ftest = 1'b0;
    if (rx_pop) begin
      n_rx_cnt = rx_cnt_q - 1'b1;
      n_rx_rd  = rx_rd_q + 1'b1;
    end
    if (wr_txcnt) begin
      n_tx_cnt = (bus_wdata_i <= 32'(MAX_FRAME)) ? bus_wdata_i[CW-1:0] : '0;
      n_tx_wr  = '0;
    end
    if (wr_txdat) begin
      n_tx_wr = tx_next;
      if (tx_next == tx_cnt_q || tx_next >= CW'(MAX_FRAME)) begin
        tx_fire  = 1'b1;
        n_tx_cnt = '0;
        n_tx_wr  = '0;
        n_ftx    = 1'b1;
        n_busy   = 1'b1;
      end
    end
    if (wr_ic) begin
      if (bus_wdata_i[FLAG_TX])      n_ftx = 1'b0;
      else if (bus_wdata_i[FLAG_RX]) n_frx = 1'b0;
      else if (bus_wdata_i[FLAG_TEST]) begin
        n_rx_cnt = '0;
        n_rx_rd  = '0;
        n_tx_cnt = '0;
        n_tx_wr  = '0;
        n_ftx    = 1'b0;
        n_frx    = 1'b0;
        n_ftest  = 1'b1;
      end
      n_busy = n_ftx || n_frx || n_ftest;
    end
    // a frame committing in the same cycle lands after the register write
    if (rx_commit && !soft_rst) begin
      n_rx_cnt = rx_len;
      n_rx_rd  = '0;
      n_frx    = 1'b1;
      n_busy   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b1;
      rx_cnt_q    <= '0;
      rx_rd_q     <= '0;
      tx_cnt_q    <= '0;
      tx_wr_q     <= '0;
      flag_tx_q   <= 1'b0;
      flag_rx_q   <= 1'b0;
      flag_test_q <= 1'b0;
      ack_q       <= 1'b0;
      pend_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      busy_q      <= n_busy;
      rx_cnt_q    <= n_rx_cnt;
      rx_rd_q     <= n_rx_rd;
      tx_cnt_q    <= n_tx_cnt;
      tx_wr_q     <= n_tx_wr;
      flag_tx_q   <= n_ftx;
      flag_rx_q   <= n_frx;
      flag_test_q <= n_ftest;
      ack_q       <= serve;
      pend_q      <= rx_pop;
      rdata_q     <= (rd && !rx_pop) ? rd_word : '0;
    end
  end

  pmb_rx_ingest #(.MAX_FRAME(MAX_FRAME), .CW(CW)) u_rx (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_data_i, .rx_last_i, .rx_ready_o,
    .gate_ok_i   (gate_ok),
    .hold_i      (rx_pop),
    .abort_i     (soft_rst),
    .in_frame_o  (rx_in_frame),
    .ram_we_o    (rx_we),
    .ram_addr_o  (rx_waddr),
    .ram_wdata_o (rx_wdata),
    .commit_o    (rx_commit),
    .commit_len_o(rx_len)
  );

  pmb_spram #(.DEPTH(BUF_DEPTH), .WIDTH(8)) u_rx_ram (
    .clk_i,
    .en_i   (rx_we || rx_pop),
    .we_i   (rx_we),
    .addr_i (rx_pop ? rx_rd_q : rx_waddr),
    .wdata_i(rx_wdata),
    .rdata_o(rx_ram_q)
  );

  pmb_spram #(.DEPTH(BUF_DEPTH), .WIDTH(8)) u_tx_ram (
    .clk_i,
    .en_i   (wr_txdat || st_re),
    .we_i   (wr_txdat),
    .addr_i (wr_txdat ? tx_wr_q : st_addr),
    .wdata_i(bus_wdata_i[7:0]),
    .rdata_o(tx_ram_q)
  );

  pmb_tx_stream #(.CW(CW)) u_tx (
    .clk_i, .rst_ni,
    .start_i   (tx_fire),
    .len_i     (tx_next),
    .busy_o    (tx_busy),
    .ram_re_o  (st_re),
    .ram_addr_o(st_addr),
    .ram_q_i   (tx_ram_q),
    .tx_valid_o, .tx_data_o, .tx_last_o, .tx_ready_i
  );

  p_ack_pulse_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);
  p_ack_follow_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_ack_o && !tx_busy |=> bus_ack_o);
  p_test_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ic |=> !flag_test_q);
  p_soft_reset_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> busy_q && rx_cnt_q == '0 && tx_cnt_q == '0 && irq_o);
  p_commit_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_commit && !soft_rst |=> irq_o && busy_q);
  p_busy_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !rx_in_frame |-> !rx_ready_o);
  p_tx_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy && bus_req_i && bus_we_i && bus_addr_i == OFF_TXDAT |=> !bus_ack_o);
  p_rx_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop |=> rx_cnt_q == $past(rx_cnt_q) - 1'b1);
endmodule

// File: tb/pmb_mailbox_nic_tb_top.sv
module pmb_mailbox_nic_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, irq;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  int n_checks = 0;
  int n_errs   = 0;
  logic [8:0] exp_q [$];

  always #2 clk = ~clk;  // 250 MHz

  pmb_mailbox_nic dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_ack_o(bus_ack),
    .irq_o(irq),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  task automatic bus_xfer(input logic we, input logic [5:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int lat);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ack && lat < 5000);
    q = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] q; int lat;
    bus_xfer(1'b1, a, d, q, lat);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] q; int lat;
    bus_xfer(1'b0, a, '0, q, lat);
    check(tag, q, exp);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic rx_send(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      do @(negedge clk); while (!rx_ready);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // driver side of the scoreboard: write a byte and queue what must leave
  task automatic tx_push(input logic [7:0] b, input logic last);
    exp_q.push_back({last, b});
    wr(6'h20, {24'hABCDEF, b});
  endtask

  task automatic tx_drain();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !tx_valid) break;
    end
    check("R12 all queued bytes left", 32'(exp_q.size()), 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check("R12 unexpected tx byte", {23'b0, tx_last, tx_data}, 32'h1FF);
      else check("R12 tx byte/last", {23'b0, tx_last, tx_data}, {23'b0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] q; int lat;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R13 irq after reset", {31'b0, irq}, 0);
    check("R13 rx_ready after reset", {31'b0, rx_ready}, 0);
    check("R13 tx_valid after reset", {31'b0, tx_valid}, 0);
    bus_xfer(1'b0, 6'h08, '0, q, lat);
    check("R13 busy after reset", q, 1);
    check("R14 ack latency", 32'(lat), 2);
    rd_chk("R13 rx count after reset", 6'h0C, 0);
    rd_chk("R13 irq ctl after reset", 6'h14, 0);
    wr(6'h08, 0);
    rd_chk("R13 busy write ignored", 6'h08, 1);
    wr(6'h0C, 55);
    rd_chk("R13 rx count write ignored", 6'h0C, 0);
    rd_chk("R1 id word 0", 6'h00, 32'h4D495053);
    rd_chk("R1 id word 1", 6'h04, 32'h4E455430);
    rd_chk("R1 info reads 0", 6'h18, 0);
    rd_chk("R1 tx data reads 0", 6'h20, 0);
    rd_chk("R1 unmapped 0x24", 6'h24, 0);
    rd_chk("R1 unmapped 0x3C", 6'h3C, 0);

    wr(6'h14, 0);
    rd_chk("R5 busy after zero write", 6'h08, 0);

    rx_send(5, 16);
    @(negedge clk);
    check("R2 irq after rx", {31'b0, irq}, 1);
    check("R6 rx_ready low while busy", {31'b0, rx_ready}, 0);
    rd_chk("R8 rx count", 6'h0C, 5);
    rd_chk("R8 busy set", 6'h08, 1);
    rd_chk("R8 rx done flag", 6'h14, 2);
    for (int i = 0; i < 5; i++) rd_chk("R8 rx byte", 6'h1C, {24'b0, pat(16, i)});
    rd_chk("R8 count drained", 6'h0C, 0);
    rd_chk("R9 empty rx read", 6'h1C, 0);
    rd_chk("R9 count unchanged", 6'h0C, 0);
    wr(6'h14, 2);
    rd_chk("R5 busy cleared", 6'h08, 0);
    @(negedge clk);
    check("R2 irq low", {31'b0, irq}, 0);

    rx_send(1514, 3);
    rd_chk("R7 long frame count", 6'h0C, 0);
    rd_chk("R7 long frame busy", 6'h08, 0);
    rd_chk("R7 long frame flags", 6'h14, 0);
    rx_send(1513, 9);
    rd_chk("R8 max accepted length", 6'h0C, 1513);
    rd_chk("R8 big frame byte 0", 6'h1C, {24'b0, pat(9, 0)});
    rd_chk("R8 big frame byte 1", 6'h1C, {24'b0, pat(9, 1)});
    wr(6'h14, 2);

    wr(6'h10, 4);
    tx_push(8'h11, 1'b0); tx_push(8'h22, 1'b0); tx_push(8'h33, 1'b0);
    rd_chk("R10 tx count loaded", 6'h10, 4);
    tx_push(8'h44, 1'b1);
    rd_chk("R11 tx count cleared", 6'h10, 0);
    rd_chk("R11 tx done flag", 6'h14, 1);
    rd_chk("R11 busy set", 6'h08, 1);
    tx_drain();
    wr(6'h14, 1);
    rd_chk("R5 busy after tx ack", 6'h08, 0);

    wr(6'h10, 2000);
    rd_chk("R10 oversize count", 6'h10, 0);
    wr(6'h10, 1514);
    rd_chk("R10 max count", 6'h10, 1514);
    wr(6'h10, 1515);
    rd_chk("R10 just over max", 6'h10, 0);
    for (int i = 0; i < 1514; i++) tx_push(pat(5, i), i == 1513);
    rd_chk("R11 cap send flag", 6'h14, 1);
    tx_drain();
    wr(6'h14, 1);

    // R12 stall: sink blocked, next data write must wait for the frame to leave
    tx_ready = 1'b0;
    wr(6'h10, 2);
    tx_push(8'hA1, 1'b0); tx_push(8'hA2, 1'b1);
    wr(6'h10, 1);
    exp_q.push_back({1'b1, 8'hA3});
    fork
      bus_xfer(1'b1, 6'h20, 32'hA3, q, lat);
      begin repeat (12) @(posedge clk); #1 tx_ready = 1'b1; end
    join
    check("R12 write stalled during send", 32'(lat > 10), 1);
    tx_drain();
    wr(6'h14, 1);

    // coincidence: rx commit and tx trigger on the same edge
    wr(6'h14, 1);
    wr(6'h10, 1);
    exp_q.push_back({1'b1, 8'h77});
    fork
      rx_send(1, 8'h5A);
      wr(6'h20, 32'h77);
    join
    rd_chk("R11 both done flags", 6'h14, 3);
    rd_chk("R8 busy with both", 6'h08, 1);
    rd_chk("R8 rx count coincident", 6'h0C, 1);
    rd_chk("R8 coincident rx byte", 6'h1C, 32'h5A);
    tx_drain();
    wr(6'h14, 3);
    rd_chk("R4 only tx done cleared", 6'h14, 2);
    rd_chk("R5 busy remains", 6'h08, 1);
    wr(6'h14, 0);
    rd_chk("R4 zero write keeps flag", 6'h14, 2);
    wr(6'h10, 7);
    wr(6'h14, 32'h8000_0002);
    rd_chk("R4 rx clear beats test", 6'h14, 0);
    rd_chk("R4 no reset on rx clear", 6'h10, 7);

    rx_send(3, 40);
    wr(6'h14, 32'h8000_0000);
    @(negedge clk);
    check("R2 irq on test flag", {31'b0, irq}, 1);
    rd_chk("R13 test flag after soft reset", 6'h14, 32'h8000_0000);
    rd_chk("R3 test flag cleared by read", 6'h14, 0);
    @(negedge clk);
    check("R3 irq low after read", {31'b0, irq}, 0);
    rd_chk("R13 busy after soft reset", 6'h08, 1);
    rd_chk("R13 rx count soft reset", 6'h0C, 0);
    rd_chk("R13 tx count soft reset", 6'h10, 0);
    wr(6'h14, 0);
    rd_chk("R5 busy after final ack", 6'h08, 0);

    report();
  end
endmodule